// File: doc/BRIEF.md
# I2C Read Target with Clock Stretching

This block is the target side of an I2C bus for read transactions only. It watches the SCL and SDA lines for START and STOP. It shifts in the seven address bits and the direction bit, then compares the address with a value supplied on a port. When the address matches and the direction bit asks for a read, the block acknowledges the address. It then holds SCL low until the local host has supplied a byte. That byte goes out most significant bit first. The master's acknowledge decides whether the block stretches again for another byte or drops off the bus.

The host side is a small register set. It holds a data buffer (the matched address byte, or the last byte the host wrote), a buffer-full flag, a direction flag, a clock-release bit and a sticky interrupt flag. The line inputs are expected to be oversampled and already synchronised to `clk`. The outputs are open-drain enables: when an enable is 1, that line is pulled low.

Top module: `i2c_read_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a START, the eight bits on the next eight SCL rising edges form the address byte, first bit most significant: bits 7..1 are the address and bit 0 is the direction (1 = read). If bits 7..1 equal `own_addr` and bit 0 is 1, `rw_flag` becomes 1 and `buf_q` takes the whole address byte.
- R2: On such a match, `sda_oe` is 1 from the eighth SCL falling edge through the ninth SCL pulse. After the ninth falling edge, `sda_oe` returns to 0 and `scl_oe` becomes 1.
- R3: A `host_wr` pulse loads `host_wdata` into `buf_q` and into the transmit shift register. The next byte sent on SDA is that value.
- R4: While the block is holding SCL, `scl_oe` stays 1 until `rel_bit` is 1 and `buf_full` is 1 together. Setting only one of them does not release SCL. Once both are 1, `scl_oe` falls within two clock cycles.
- R5: Data bits appear on SDA most significant bit first. `sda_oe` changes only while SCL is low or in response to START/STOP, so SDA is stable while SCL is high.
- R6: `irq` is set on the ninth SCL falling edge of every acknowledged address byte and of every transmitted data byte. It clears only on an `irq_clr` pulse. When the set and the clear fall in the same cycle, the set wins.
- R7: The master's acknowledge is taken from SDA on the ninth SCL rising edge of each transmitted byte.
- R8: An acknowledge of 1 (NACK) releases both lines at the ninth falling edge. The block then ignores further SCL pulses until a START.
- R9: An acknowledge of 0 clears `rel_bit` and holds SCL low again at the ninth falling edge.
- R10: A START aborts any byte in progress, releases both lines and clears `rw_flag`, then begins a new address byte. A STOP releases both lines, clears `rw_flag` and returns the block to idle.
- R11: `buf_full` is set by `host_wr` and cleared at the SCL falling edge that ends the eighth data bit. When a write and that edge fall in the same cycle, the write wins.
- R12: An address that does not match, or a matching address with direction bit 0, produces no acknowledge, no SCL hold and no `irq` until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | ADDR_W | Address this target answers to |
| host_wr | input | 1 | Host write strobe for the data buffer |
| host_wdata | input | DATA_W | Byte written by the host |
| rel_set | input | 1 | Host pulse that sets the clock-release bit |
| irq_clr | input | 1 | Host pulse that clears the interrupt flag |
| buf_q | output | DATA_W | Data buffer contents |
| buf_full | output | 1 | Buffer written and not yet shifted out |
| rw_flag | output | 1 | Matched read transaction in progress |
| rel_bit | output | 1 | Clock-release control bit |
| irq | output | 1 | Sticky byte-complete interrupt |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is the interrupt set at a ninth falling edge and a host clear of that interrupt. The second is the buffer-full clear at the end of the eighth data bit and a host write of the next byte. The bench provokes each pair by raising the bus-master SCL model's falling edge and the host pulse at the same sampling point. It then judges the result at the ports: `irq` must remain set, `buf_full` must remain set, and the following byte must be the value written in that cycle, released by `rel_set` alone. Address handling is swept over all 128 addresses with reads of several data patterns, and a START and a STOP are also placed in the middle of a byte.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_AACK = 3'd2,
      ST_HOLD = 3'd3,
      ST_TX   = 3'd4,
      ST_TACK = 3'd5,
      ST_IGN  = 3'd6
   } rt_state_e;

endpackage

// File: rtl/i2c_rt_lines.sv
module i2c_rt_lines (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      scl_rise  = scl_i & ~scl_q;
      scl_fall  = ~scl_i & scl_q;
      bus_start = scl_i & scl_q & sda_q & ~sda_i;
      bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
   end
endmodule

// File: rtl/i2c_rt_host.sv
module i2c_rt_host #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              rel_set,
   input  logic              irq_clr,
   input  logic              ev_addr_hit,
   input  logic [DATA_W-1:0] addr_byte,
   input  logic              ev_ninth,
   input  logic              ev_hold,
   input  logic              ev_sent,
   input  logic              ev_clr_rw,
   output logic [DATA_W-1:0] buf_q,
   output logic              buf_full,
   output logic              rw_flag,
   output logic              rel_bit,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q    <= '0;
         buf_full <= 1'b0;
         rw_flag  <= 1'b0;
         rel_bit  <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (host_wr)          buf_q <= host_wdata;
         else if (ev_addr_hit) buf_q <= addr_byte;

         if (host_wr)      buf_full <= 1'b1;
         else if (ev_sent) buf_full <= 1'b0;

         if (ev_addr_hit)    rw_flag <= 1'b1;
         else if (ev_clr_rw) rw_flag <= 1'b0;

         if (rel_set)      rel_bit <= 1'b1;
         else if (ev_hold) rel_bit <= 1'b0;

         if (ev_ninth)     irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_rt_core.sv
module i2c_rt_core
   import i2c_rt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              rel_bit,
   input  logic              buf_full,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              ev_addr_hit,
   output logic [DATA_W-1:0] addr_byte,
   output logic              ev_ninth,
   output logic              ev_hold,
   output logic              ev_sent,
   output logic              ev_clr_rw,
   output rt_state_e         state
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;
   logic              ack_q;
   logic              hit;
   logic              byte_in;
   logic              rel_go;

   always_comb begin
      hit         = (rx_sr[DATA_W-1 -: ADDR_W] == own_addr) && rx_sr[0];
      byte_in     = (state == ST_ADDR) && scl_fall && (cnt == LAST);
      ev_addr_hit = byte_in && hit;
      addr_byte   = rx_sr;
      ev_ninth    = scl_fall && ((state == ST_AACK) || (state == ST_TACK));
      ev_hold     = ev_ninth && ((state == ST_AACK) || !ack_q);
      ev_sent     = (state == ST_TX) && scl_fall && (cnt == LAST);
      ev_clr_rw   = bus_start | bus_stop;
      rel_go      = (state == ST_HOLD) && rel_bit && buf_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         rx_sr  <= '0;
         tx_sr  <= '0;
         ack_q  <= 1'b1;
         scl_oe <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         if (bus_stop) begin
            state  <= ST_IDLE;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
         end else if (bus_start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     rx_sr <= {rx_sr[DATA_W-2:0], sda_i};
                     cnt   <= cnt + ONE;
                  end
                  if (byte_in) begin
                     if (hit) begin
                        state  <= ST_AACK;
                        sda_oe <= 1'b1;
                     end else begin
                        state  <= ST_IGN;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     scl_oe <= 1'b1;
                     state  <= ST_HOLD;
                  end
               end
               ST_HOLD: begin
                  if (rel_go) begin
                     scl_oe <= 1'b0;
                     sda_oe <= ~tx_sr[DATA_W-1];
                     cnt    <= '0;
                     state  <= ST_TX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) cnt <= cnt + ONE;
                  if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TACK;
                     end else begin
                        tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
                        sda_oe <= ~tx_sr[DATA_W-2];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) ack_q <= sda_i;
                  if (scl_fall) begin
                     if (!ack_q) begin
                        scl_oe <= 1'b1;
                        state  <= ST_HOLD;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
         if (host_wr) tx_sr <= host_wdata;
      end
   end
endmodule

// File: rtl/i2c_read_target.sv
module i2c_read_target
   import i2c_rt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              rel_set,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] buf_q,
   output logic              buf_full,
   output logic              rw_flag,
   output logic              rel_bit,
   output logic              irq
);
   generate
      if (DATA_W != ADDR_W + 1) begin : g_bad_width
         $error("i2c_read_target: DATA_W must equal ADDR_W + 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("i2c_read_target: ADDR_W must be at least 2");
      end
   endgenerate

   logic              w_rise;
   logic              w_fall;
   logic              w_start;
   logic              w_stop;
   logic              w_hit;
   logic [DATA_W-1:0] w_abyte;
   logic              w_ninth;
   logic              w_hold;
   logic              w_sent;
   logic              w_clr_rw;
   rt_state_e         w_state;

   i2c_rt_lines u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (w_rise),
      .scl_fall  (w_fall),
      .bus_start (w_start),
      .bus_stop  (w_stop)
   );

   i2c_rt_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (w_rise),
      .scl_fall    (w_fall),
      .bus_start   (w_start),
      .bus_stop    (w_stop),
      .sda_i       (sda_i),
      .own_addr    (own_addr),
      .host_wr     (host_wr),
      .host_wdata  (host_wdata),
      .rel_bit     (rel_bit),
      .buf_full    (buf_full),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe),
      .ev_addr_hit (w_hit),
      .addr_byte   (w_abyte),
      .ev_ninth    (w_ninth),
      .ev_hold     (w_hold),
      .ev_sent     (w_sent),
      .ev_clr_rw   (w_clr_rw),
      .state       (w_state)
   );

   i2c_rt_host #(.DATA_W(DATA_W)) u_host (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_wdata  (host_wdata),
      .rel_set     (rel_set),
      .irq_clr     (irq_clr),
      .ev_addr_hit (w_hit),
      .addr_byte   (w_abyte),
      .ev_ninth    (w_ninth),
      .ev_hold     (w_hold),
      .ev_sent     (w_sent),
      .ev_clr_rw   (w_clr_rw),
      .buf_q       (buf_q),
      .buf_full    (buf_full),
      .rw_flag     (rw_flag),
      .rel_bit     (rel_bit),
      .irq         (irq)
   );
endmodule

// File: rtl/i2c_read_target_chk.sv
module i2c_read_target_chk
   import i2c_rt_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      scl_i,
   input logic      scl_oe,
   input logic      sda_oe,
   input logic      irq,
   input logic      irq_clr,
   input logic      rel_bit,
   input logic      buf_full,
   input logic      host_wr,
   input logic      rw_flag,
   input logic      bus_start,
   input logic      bus_stop,
   input rt_state_e state
);
   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   assert_hold_until_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && !(rel_bit && buf_full) && !bus_start && !bus_stop) |=> scl_oe);

   assert_sda_moves_low_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!$past(scl_i) || $past(bus_start) || $past(bus_stop)));

   assert_write_sets_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> buf_full);

   assert_ignore_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGN) |-> (!scl_oe && !sda_oe));

   assert_match_acks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rw_flag) |-> sda_oe);

   assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (!scl_oe && !sda_oe && !rw_flag));
endmodule

bind i2c_read_target i2c_read_target_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .irq       (irq),
   .irq_clr   (irq_clr),
   .rel_bit   (rel_bit),
   .buf_full  (buf_full),
   .host_wr   (host_wr),
   .rw_flag   (rw_flag),
   .bus_start (w_start),
   .bus_stop  (w_stop),
   .state     (w_state)
);

// File: tb/sim_i2c_read_target.sv
module sim_i2c_read_target;
   localparam int H = 4;
   localparam logic [6:0] OWN = 7'h2C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       rel_set = 1'b0;
   logic       irq_clr = 1'b0;
   logic       scl_oe, sda_oe, buf_full, rw_flag, rel_bit, irq;
   logic [7:0] buf_q;
   logic       scl_bus, sda_bus;

   int n_chk = 0;
   int n_fail = 0;

   assign scl_bus = scl_m & ~scl_oe;
   assign sda_bus = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   i2c_read_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
      .host_wr(host_wr), .host_wdata(host_wdata), .rel_set(rel_set),
      .irq_clr(irq_clr), .buf_q(buf_q), .buf_full(buf_full),
      .rw_flag(rw_flag), .rel_bit(rel_bit), .irq(irq)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic hw(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; scl_m = 1'b1; hw(H);
      sda_m = 1'b0; hw(H);
      scl_m = 1'b0; hw(H);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b1; hw(H);
   endtask

   task automatic m_send(bit b, bit clr_at_fall);
      sda_m = b; hw(H);
      scl_m = 1'b1; hw(1);
      while (!scl_bus) hw(1);
      hw(H);
      scl_m = 1'b0;
      if (clr_at_fall) irq_clr = 1'b1;
      hw(1);
      irq_clr = 1'b0;
      hw(H - 1);
   endtask

   task automatic m_recv(output bit b, input bit wr_at_fall, input logic [7:0] wd);
      sda_m = 1'b1; hw(H);
      scl_m = 1'b1; hw(1);
      while (!scl_bus) hw(1);
      hw(H);
      b = sda_bus;
      scl_m = 1'b0;
      if (wr_at_fall) begin host_wr = 1'b1; host_wdata = wd; end
      hw(1);
      host_wr = 1'b0;
      hw(H - 1);
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit wr_last, input logic [7:0] wd);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         m_recv(b, (i == 0) && wr_last, wd);
         v[i] = b;
      end
   endtask

   task automatic send_addr(logic [6:0] a, bit rw, output bit ak);
      for (int i = 6; i >= 0; i--) m_send(a[i], 1'b0);
      m_send(rw, 1'b0);
      m_recv(ak, 1'b0, 8'h00);
   endtask

   task automatic p_write(logic [7:0] d);
      host_wdata = d; host_wr = 1'b1; hw(1); host_wr = 1'b0;
   endtask

   task automatic p_rel();
      rel_set = 1'b1; hw(1); rel_set = 1'b0;
   endtask

   task automatic p_clr();
      irq_clr = 1'b1; hw(1); irq_clr = 1'b0;
   endtask

   function automatic logic [7:0] pat(int seed, int idx);
      if (seed == 0) return 8'h00;
      if (seed == 1) return 8'hFF;
      return 8'((seed * 59 + idx * 101 + 17) & 255);
   endfunction

   task automatic do_read(int seed, int nb, bit tail);
      bit ak;
      logic [7:0] rb, d;
      m_start();
      send_addr(OWN, 1'b1, ak);
      chk("R2", "address ack level", ak, 0);
      chk("R6", "irq after address", irq, 1);
      chk("R1", "rw_flag on match", rw_flag, 1);
      chk("R1", "buffer holds address byte", buf_q, {OWN, 1'b1});
      chk("R2", "scl held after address", scl_oe, 1);
      p_clr();
      chk("R6", "irq cleared by host", irq, 0);
      for (int idx = 0; idx < nb; idx++) begin
         d = pat(seed, idx);
         if (idx == 0) begin
            p_rel(); hw(20);
            chk("R4", "held with release bit but empty buffer", scl_oe, 1);
            p_write(d); hw(3);
         end else begin
            p_write(d); hw(20);
            chk("R4", "held with full buffer but no release bit", scl_oe, 1);
            p_rel(); hw(3);
         end
         chk("R4", "scl released", scl_oe, 0);
         chk("R3", "buffer holds written byte", buf_q, d);
         recv_byte(rb, 1'b0, 8'h00);
         chk("R5", "byte seen on SDA", rb, d);
         chk("R11", "buf_full after last bit", buf_full, 0);
         m_send(idx == nb - 1, 1'b0);
         chk("R6", "irq after data byte", irq, 1);
         if (idx != nb - 1) begin
            chk("R9", "scl held after ACK", scl_oe, 1);
            chk("R9", "release bit cleared", rel_bit, 0);
         end else begin
            chk("R8", "lines free after NACK", {scl_oe, sda_oe}, 0);
         end
         p_clr();
      end
      if (tail) begin
         recv_byte(rb, 1'b0, 8'h00);
         chk("R8", "clocks after NACK ignored", rb, 8'hFF);
         chk("R8", "no irq after NACK", irq, 0);
      end
      m_stop();
      chk("R10", "rw_flag after STOP", rw_flag, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit ak;
      logic [7:0] rb;
      hw(3);
      rst_n = 1'b1;
      hw(2);
      chk("R10", "reset lines", {scl_oe, sda_oe}, 0);
      chk("R6", "reset irq", irq, 0);
      chk("R11", "reset buf_full", buf_full, 0);
      chk("R1", "reset rw_flag", rw_flag, 0);

      // R1 R12: sweep every address with a read request
      for (int a = 0; a < 128; a++) begin
         if (7'(a) == OWN) begin
            do_read(2, 2, 1'b0);
         end else begin
            m_start();
            send_addr(7'(a), 1'b1, ak);
            chk("R12", "no ack on mismatch", ak, 1);
            chk("R12", "no irq on mismatch", irq, 0);
            chk("R12", "lines free on mismatch", {scl_oe, sda_oe}, 0);
            if (a % 32 == 0) begin
               recv_byte(rb, 1'b0, 8'h00);
               chk("R12", "traffic ignored after mismatch", rb, 8'hFF);
            end
            m_stop();
         end
      end

      // R12: matching address with write direction is ignored
      m_start();
      send_addr(OWN, 1'b0, ak);
      chk("R12", "no ack for write direction", ak, 1);
      chk("R12", "rw_flag stays clear", rw_flag, 0);
      recv_byte(rb, 1'b0, 8'h00);
      chk("R12", "write direction traffic ignored", rb, 8'hFF);
      chk("R12", "no irq for write direction", irq, 0);
      m_stop();

      // R3 R5 R7: several patterns and lengths
      for (int s = 0; s < 6; s++) do_read(s, (s % 3) + 1, s[0]);

      // R6 R11: coincident host actions
      m_start();
      send_addr(OWN, 1'b1, ak);
      p_clr();
      p_write(8'hC3); p_rel(); hw(3);
      recv_byte(rb, 1'b1, 8'h3C);
      chk("R5", "first byte of clash test", rb, 8'hC3);
      chk("R11", "write wins over last-bit clear", buf_full, 1);
      m_send(1'b0, 1'b1);
      chk("R6", "set wins over same-cycle clear", irq, 1);
      chk("R9", "held after ACK in clash test", scl_oe, 1);
      p_clr();
      p_rel(); hw(3);
      chk("R4", "release with preloaded buffer", scl_oe, 0);
      recv_byte(rb, 1'b0, 8'h00);
      chk("R3", "preloaded byte sent", rb, 8'h3C);
      m_send(1'b1, 1'b0);
      p_clr();
      m_stop();

      // R10: repeated START inside a data byte
      m_start();
      send_addr(OWN, 1'b1, ak);
      p_clr();
      p_write(8'hFF); p_rel(); hw(3);
      for (int i = 0; i < 3; i++) begin bit b; m_recv(b, 1'b0, 8'h00); end
      sda_m = 1'b1; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b0; hw(H);
      chk("R10", "START mid-byte frees lines", {scl_oe, sda_oe}, 0);
      chk("R10", "START clears rw_flag", rw_flag, 0);
      scl_m = 1'b0; hw(H);
      send_addr(OWN, 1'b1, ak);
      chk("R10", "address after repeated START acked", ak, 0);
      chk("R1", "buffer holds new address byte", buf_q, {OWN, 1'b1});
      p_clr();
      p_write(8'h5A); p_rel(); hw(3);
      recv_byte(rb, 1'b0, 8'h00);
      chk("R5", "byte after repeated START", rb, 8'h5A);
      m_send(1'b1, 1'b0);
      p_clr();
      m_stop();

      // R10: STOP inside the address byte
      m_start();
      for (int i = 6; i >= 3; i--) m_send(OWN[i], 1'b0);
      sda_m = 1'b0; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b1; hw(H);
      chk("R10", "STOP mid-address frees lines", {scl_oe, sda_oe}, 0);
      chk("R10", "no irq after aborted address", irq, 0);
      do_read(4, 1, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule